// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the base address registers of one configuration function and turns them into address windows. Software programs each slot through configuration writes and reads it back through a combinational read port. Incoming I/O and memory transactions are compared against every enabled window. A matching transaction produces a hit, the number of the slot that owns the window, and the offset of the address from the window base.

Each slot has a kind and a power-of-two size, both fixed by parameters. A slot can be an I/O window, a 32-bit memory window, the lower half of a 64-bit prefetchable memory window, the upper half of such a window, or unused. A 64-bit window takes two consecutive slots: the lower slot holds address bits 31:0 and the following slot holds bits 63:32, and each half is masked on its own. Decode of each window is gated by the I/O-enable or memory-enable bit of a small command register.

Slot n sits at configuration byte offset 0x10 + 4*n. The command register sits at offset 0x04. The default configuration is: slot 0 is I/O with 32 bytes; slot 1 is 32-bit memory with 4 KiB; slots 2 and 3 form one 64-bit window of 8 GiB; slot 4 is unused; slot 5 is 32-bit memory with 256 bytes.

Top module: `bar_decode_unit`

## Requirements
- R1: Writing 0xFFFFFFFF to a slot makes it read back the complement of (size − 1) in the bits the slot holds, plus its fixed low type bits. For the default configuration the slots read 0xFFFFFFE1, 0xFFFFF000, 0x0000000C, 0xFFFFFFFE, 0x00000000 and 0xFFFFFF00.
- R2: A write to a slot offset (0x10 + 4*n) updates the slot only when it is 4 bytes wide and its offset is a multiple of 4. Any other write to the slot range leaves every slot unchanged.
- R3: An I/O slot always reads back with bit 0 = 1 and bit 1 = 0.
- R4: A 32-bit memory slot always reads back with bits [3:0] = 0000.
- R5: The lower slot of a 64-bit window reads back with bits [3:0] = 1100. The next slot holds address bits 63:32, masked by the upper half of the 64-bit size mask. The window base is {upper slot, lower slot}.
- R6: Bit 0 of the command register enables I/O decode and bit 1 enables memory decode. A command write of 1, 2 or 4 bytes at offset 0x04 loads both bits from write data bits 1:0. Offset 0x04 reads them back in bits 1:0. From the next cycle the new value gates every window of the matching space.
- R7: A transaction hits a window only when all of the following hold: it is valid, its space is enabled, its length is at least 1, and every byte of [addr, addr + len) lies in [base, base + size). On a hit, the offset output is addr − base and the slot output is the lower slot of the window. If windows overlap, the lowest slot wins.
- R8: An unused slot reads zero after any write and never produces a hit.
- R9: A new base is used for decode from the cycle after the write edge. A transaction in the same cycle as the write is decoded against the old base.
- R10: After reset every slot holds a zero base and the command register is zero, so no transaction hits. Reads of offsets that are neither the command register nor a slot return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_off | input | 8 | Byte offset of the write |
| cfg_wr_size | input | 3 | Write width in bytes (1, 2 or 4) |
| cfg_wr_data | input | 32 | Write value, right aligned |
| cfg_rd_off | input | 8 | Byte offset of the read (dword selected) |
| cfg_rd_data | output | 32 | Read value of the selected dword |
| txn_valid | input | 1 | A transaction is presented |
| txn_is_io | input | 1 | 1 for I/O space, 0 for memory space |
| txn_addr | input | 64 | Transaction start address |
| txn_len | input | 4 | Transaction length in bytes |
| hit_valid | output | 1 | The transaction falls in an enabled window |
| hit_slot | output | 3 | Lower slot number of the matching window |
| hit_offset | output | 64 | Address minus window base |

## Verification
A configuration write that moves a base, or that flips a command enable, can arrive in the same cycle as a transaction aimed at that window. The bench provokes this by driving both in one cycle. It first samples the decode before the clock edge and expects the old base or enable to apply. It then samples again after the edge and expects the new value to apply. The random phase mixes base writes, command writes and transactions near window edges, so the same overlap also occurs without being scripted.

// File: rtl/bardec_pkg.sv
package bardec_pkg;

    typedef enum logic [2:0] {
        BK_NONE  = 3'd0,
        BK_IO    = 3'd1,
        BK_MEM32 = 3'd2,
        BK_MEM64 = 3'd3,
        BK_MEMHI = 3'd4
    } bar_kind_e;

    localparam int KIND_W  = 3;
    localparam int SZLOG_W = 6;
    localparam int ADDR_W  = 64;
    localparam int DW      = 32;

    localparam logic [7:0] CMD_OFF  = 8'h04;
    localparam logic [7:0] BAR0_OFF = 8'h10;

    typedef struct packed {
        logic mem_en;
        logic io_en;
    } cmd_t;

    typedef struct packed {
        logic              valid;
        logic              is_io;
        logic [3:0]        len;
        logic [ADDR_W-1:0] addr;
    } txn_t;

    // fixed type bits that every read of a slot carries
    function automatic logic [DW-1:0] kind_low_bits(bar_kind_e k);
        case (k)
            BK_IO:    return 32'h0000_0001;
            BK_MEM64: return 32'h0000_000C;
            default:  return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] span_mask(int unsigned lg);
        return ~((64'd1 << lg) - 64'd1);
    endfunction

    // writable bits of one slot word, derived from its own or its partner's size
    function automatic logic [DW-1:0] slot_mask(bar_kind_e k, int unsigned own_lg,
                                                int unsigned lower_lg);
        logic [ADDR_W-1:0] m;
        m = '0;
        case (k)
            BK_IO: begin
                m = span_mask(own_lg);
                return m[DW-1:0] & 32'hFFFF_FFFC;
            end
            BK_MEM32, BK_MEM64: begin
                m = span_mask(own_lg);
                return m[DW-1:0] & 32'hFFFF_FFF0;
            end
            BK_MEMHI: begin
                m = span_mask(lower_lg);
                return m[ADDR_W-1:DW];
            end
            default: return '0;
        endcase
    endfunction

    function automatic logic kind_is_mem(bar_kind_e k);
        return (k == BK_MEM32) || (k == BK_MEM64);
    endfunction

endpackage

// File: rtl/bardec_cfg_wr.sv
module bardec_cfg_wr
    import bardec_pkg::*;
#(
    parameter int NUM_SLOTS = 6
) (
    input  logic                 wr_en,
    input  logic [7:0]           wr_off,
    input  logic [2:0]           wr_size,
    output logic [NUM_SLOTS-1:0] slot_we,
    output logic                 cmd_we
);
    localparam int BAR_END = int'(BAR0_OFF) + 4 * NUM_SLOTS;

    logic       in_bar_range;
    logic       dword_ok;
    logic       lane_aligned;
    logic [5:0] idx;

    always_comb begin
        idx          = 6'((wr_off - BAR0_OFF) >> 2);
        in_bar_range = (int'(wr_off) >= int'(BAR0_OFF)) && (int'(wr_off) < BAR_END);
        dword_ok     = (wr_size == 3'd4) && (wr_off[1:0] == 2'b00);
        case (wr_size)
            3'd1:    lane_aligned = 1'b1;
            3'd2:    lane_aligned = ~wr_off[0];
            3'd4:    lane_aligned = dword_ok;
            default: lane_aligned = 1'b0;
        endcase
        cmd_we = wr_en && lane_aligned && (wr_off == CMD_OFF);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_we[i] = wr_en && in_bar_range && dword_ok && (idx == 6'(i));
        end
    end

endmodule

// File: rtl/bardec_slot.sv
module bardec_slot
    import bardec_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] addr_bits
);
    logic [DW-1:0] q;

    // an all-zero mask (unused slot) keeps the word at zero for ever
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & MASK;
        end
    end

    assign addr_bits = q;

endmodule

// File: rtl/bardec_window.sv
module bardec_window
    import bardec_pkg::*;
#(
    parameter bar_kind_e   KIND  = BK_MEM32,
    parameter int unsigned SZLOG = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  cmd_t              cmd,
    input  txn_t              txn,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W:0] SPAN = 65'd1 << SZLOG;

    logic [ADDR_W:0] txn_end;
    logic [ADDR_W:0] win_end;
    logic            space_ok;
    logic            lower_ok;
    logic            upper_ok;

    always_comb begin
        txn_end = {1'b0, txn.addr} + {61'd0, txn.len};
        win_end = {1'b0, base} + SPAN;
        if (txn.is_io) begin
            space_ok = (KIND == BK_IO) && cmd.io_en;
        end else begin
            space_ok = kind_is_mem(KIND) && cmd.mem_en;
        end
        lower_ok = txn.addr >= base;
        upper_ok = txn_end <= win_end;
        hit      = txn.valid && space_ok && (txn.len != 4'd0) && lower_ok && upper_ok;
        offset   = txn.addr - base;
    end

endmodule

// File: rtl/bar_decode_unit.sv
module bar_decode_unit
    import bardec_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter logic [KIND_W*NUM_SLOTS-1:0] SLOT_KIND_VEC =
        {BK_MEM32, BK_NONE, BK_MEMHI, BK_MEM64, BK_MEM32, BK_IO},
    parameter logic [SZLOG_W*NUM_SLOTS-1:0] SLOT_SZLOG_VEC =
        {6'd8, 6'd0, 6'd0, 6'd33, 6'd12, 6'd5},
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_off,
    input  logic [2:0]        cfg_wr_size,
    input  logic [31:0]       cfg_wr_data,
    input  logic [7:0]        cfg_rd_off,
    output logic [31:0]       cfg_rd_data,
    input  logic              txn_valid,
    input  logic              txn_is_io,
    input  logic [63:0]       txn_addr,
    input  logic [3:0]        txn_len,
    output logic              hit_valid,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [63:0]       hit_offset
);
    localparam int RD_END = int'(BAR0_OFF) + 4 * NUM_SLOTS;

    cmd_t                    cmd_q;
    logic [NUM_SLOTS-1:0]    slot_we;
    logic                    cmd_we;
    logic [DW-1:0]           addr_bits [NUM_SLOTS];
    logic [DW*NUM_SLOTS-1:0] slot_rd_flat;
    logic [NUM_SLOTS-1:0]    hit_vec;
    logic [ADDR_W-1:0]       win_off [NUM_SLOTS];
    txn_t                    txn;
    logic [5:0]              rd_idx;

    assign txn = '{valid: txn_valid, is_io: txn_is_io, len: txn_len, addr: txn_addr};

    bardec_cfg_wr #(.NUM_SLOTS(NUM_SLOTS)) u_wr (
        .wr_en   (cfg_wr_en),
        .wr_off  (cfg_wr_off),
        .wr_size (cfg_wr_size),
        .slot_we (slot_we),
        .cmd_we  (cmd_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_we) begin
            cmd_q.io_en  <= cfg_wr_data[0];
            cmd_q.mem_en <= cfg_wr_data[1];
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam bar_kind_e KIND =
            bar_kind_e'(SLOT_KIND_VEC[KIND_W*i +: KIND_W]);
        localparam int unsigned OWN_LG =
            int'(SLOT_SZLOG_VEC[SZLOG_W*i +: SZLOG_W]);
        localparam int unsigned LOW_LG =
            int'(SLOT_SZLOG_VEC[SZLOG_W*((i > 0) ? i - 1 : 0) +: SZLOG_W]);

        bardec_slot #(.MASK(slot_mask(KIND, OWN_LG, LOW_LG))) u_slot (
            .clk       (clk),
            .rst       (rst),
            .we        (slot_we[i]),
            .wdata     (cfg_wr_data),
            .addr_bits (addr_bits[i])
        );

        assign slot_rd_flat[DW*i +: DW] = addr_bits[i] | kind_low_bits(KIND);

        if (KIND == BK_IO || KIND == BK_MEM32 ||
            (KIND == BK_MEM64 && i + 1 < NUM_SLOTS)) begin : g_win
            logic [ADDR_W-1:0] base;
            if (KIND == BK_MEM64) begin : g_wide
                assign base = {addr_bits[i+1], addr_bits[i]};
            end else begin : g_narrow
                assign base = {32'd0, addr_bits[i]};
            end
            bardec_window #(.KIND(KIND), .SZLOG(OWN_LG)) u_win (
                .base   (base),
                .cmd    (cmd_q),
                .txn    (txn),
                .hit    (hit_vec[i]),
                .offset (win_off[i])
            );
        end else begin : g_nowin
            assign hit_vec[i] = 1'b0;
            assign win_off[i] = '0;
        end
    end

    // lowest slot number wins when windows overlap
    always_comb begin
        hit_valid  = |hit_vec;
        hit_slot   = '0;
        hit_offset = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_slot   = SLOT_W'(i);
                hit_offset = win_off[i];
            end
        end
    end

    always_comb begin
        rd_idx      = 6'((cfg_rd_off - BAR0_OFF) >> 2);
        cfg_rd_data = '0;
        if (cfg_rd_off[7:2] == CMD_OFF[7:2]) begin
            cfg_rd_data = {30'd0, cmd_q.mem_en, cmd_q.io_en};
        end else if (int'(cfg_rd_off) >= int'(BAR0_OFF) && int'(cfg_rd_off) < RD_END) begin
            cfg_rd_data = slot_rd_flat[DW*int'(rd_idx) +: DW];
        end
    end

endmodule

// File: rtl/bar_decode_unit_chk.sv
module bar_decode_unit_chk
    import bardec_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter logic [KIND_W*NUM_SLOTS-1:0] SLOT_KIND_VEC = '0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_wr_en,
    input logic [7:0]              cfg_wr_off,
    input logic [2:0]              cfg_wr_size,
    input logic [7:0]              cfg_rd_off,
    input logic [31:0]             cfg_rd_data,
    input logic                    txn_valid,
    input logic                    txn_is_io,
    input logic                    hit_valid,
    input cmd_t                    cmd_q,
    input logic [DW*NUM_SLOTS-1:0] slot_rd_flat
);
    localparam int BAR_END = int'(BAR0_OFF) + 4 * NUM_SLOTS;

    logic      rd_in_bar;
    logic      wr_in_bar;
    logic [5:0] rd_idx;
    bar_kind_e rd_kind;

    always_comb begin
        rd_in_bar = (int'(cfg_rd_off) >= int'(BAR0_OFF)) && (int'(cfg_rd_off) < BAR_END);
        wr_in_bar = (int'(cfg_wr_off) >= int'(BAR0_OFF)) && (int'(cfg_wr_off) < BAR_END);
        rd_idx    = 6'((cfg_rd_off - BAR0_OFF) >> 2);
        rd_kind   = rd_in_bar ? bar_kind_e'(SLOT_KIND_VEC[KIND_W*int'(rd_idx) +: KIND_W])
                              : BK_NONE;
    end

    AST_SUBWORD_BAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && wr_in_bar && (cfg_wr_size != 3'd4 || cfg_wr_off[1:0] != 2'b00))
        |=> $stable(slot_rd_flat)); // R2

    AST_IO_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_in_bar && rd_kind == BK_IO) |-> (cfg_rd_data[1:0] == 2'b01)); // R3

    AST_MEM32_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_in_bar && rd_kind == BK_MEM32) |-> (cfg_rd_data[3:0] == 4'h0)); // R4

    AST_MEM64_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_in_bar && rd_kind == BK_MEM64) |-> (cfg_rd_data[3:0] == 4'hC)); // R5

    AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_is_io && !cmd_q.io_en) |-> !hit_valid); // R6

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_is_io && !cmd_q.mem_en) |-> !hit_valid); // R6

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |-> !hit_valid); // R7

    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_in_bar && rd_kind == BK_NONE) |-> (cfg_rd_data == 32'd0)); // R8

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> $stable(slot_rd_flat)); // R9

endmodule

bind bar_decode_unit bar_decode_unit_chk #(
    .NUM_SLOTS     (NUM_SLOTS),
    .SLOT_KIND_VEC (SLOT_KIND_VEC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_off   (cfg_wr_off),
    .cfg_wr_size  (cfg_wr_size),
    .cfg_rd_off   (cfg_rd_off),
    .cfg_rd_data  (cfg_rd_data),
    .txn_valid    (txn_valid),
    .txn_is_io    (txn_is_io),
    .hit_valid    (hit_valid),
    .cmd_q        (cmd_q),
    .slot_rd_flat (slot_rd_flat)
);

// File: tb/sim_bar_decode_unit.sv
module sim_bar_decode_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;
    // kind codes: 0 unused, 1 I/O, 2 mem32, 3 mem64 lower, 4 mem64 upper
    localparam int B_KIND [NS] = '{1, 2, 3, 4, 0, 2};
    localparam int B_LG   [NS] = '{5, 12, 33, 0, 0, 8};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_off = '0;
    logic [2:0]  cfg_wr_size = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_off = '0;
    logic [31:0] cfg_rd_data;
    logic        txn_valid = 1'b0;
    logic        txn_is_io = 1'b0;
    logic [63:0] txn_addr = '0;
    logic [3:0]  txn_len = '0;
    logic        hit_valid;
    logic [2:0]  hit_slot;
    logic [63:0] hit_offset;

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] m_bar [NS];
    bit          m_io;
    bit          m_mem;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bar_decode_unit #(
        .NUM_SLOTS      (NS),
        .SLOT_KIND_VEC  ({3'd2, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1}),
        .SLOT_SZLOG_VEC ({6'd8, 6'd0, 6'd0, 6'd33, 6'd12, 6'd5})
    ) u0 (
        .clk, .rst, .cfg_wr_en, .cfg_wr_off, .cfg_wr_size, .cfg_wr_data,
        .cfg_rd_off, .cfg_rd_data, .txn_valid, .txn_is_io, .txn_addr, .txn_len,
        .hit_valid, .hit_slot, .hit_offset
    );

    function automatic logic [31:0] m_mask(int s);
        logic [63:0] sm;
        case (B_KIND[s])
            1: begin sm = ~((64'd1 << B_LG[s]) - 64'd1); return sm[31:0] & 32'hFFFF_FFFC; end
            2, 3: begin sm = ~((64'd1 << B_LG[s]) - 64'd1); return sm[31:0] & 32'hFFFF_FFF0; end
            4: begin sm = ~((64'd1 << B_LG[s-1]) - 64'd1); return sm[63:32]; end
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] m_low(int s);
        if (B_KIND[s] == 1) return 32'h1;
        if (B_KIND[s] == 3) return 32'hC;
        return 32'h0;
    endfunction

    function automatic void m_apply(int off, int size, logic [31:0] d);
        bit al;
        al = (size == 1) || (size == 2 && off % 2 == 0) || (size == 4 && off % 4 == 0);
        if (off >= 16 && off < 16 + 4 * NS && size == 4 && off % 4 == 0)
            m_bar[(off - 16) / 4] = d & m_mask((off - 16) / 4);
        if (off == 4 && al) begin
            m_io  = d[0];
            m_mem = d[1];
        end
    endfunction

    function automatic logic [31:0] m_read(int off);
        if (off / 4 == 1) return {30'd0, m_mem, m_io};
        if (off >= 16 && off < 16 + 4 * NS) return m_bar[(off - 16) / 4] | m_low((off - 16) / 4);
        return 32'd0;
    endfunction

    function automatic logic [63:0] m_base(int w);
        if (B_KIND[w] == 3) return {m_bar[w+1], m_bar[w]};
        return {32'd0, m_bar[w]};
    endfunction

    function automatic void m_decode(logic [63:0] a, int len, bit io,
                                     output bit h, output int s, output logic [63:0] o);
        h = 0; s = 0; o = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            bit ok;
            logic [64:0] e_t, e_w;
            ok = io ? (B_KIND[i] == 1 && m_io) : ((B_KIND[i] == 2 || B_KIND[i] == 3) && m_mem);
            e_t = {1'b0, a} + 65'(len);
            e_w = {1'b0, m_base(i)} + (65'd1 << B_LG[i]);
            if (ok && len > 0 && a >= m_base(i) && e_t <= e_w) begin
                h = 1; s = i; o = a - m_base(i);
            end
        end
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input int size, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_off = 8'(off); cfg_wr_size = 3'(size); cfg_wr_data = d;
        @(posedge clk);
        m_apply(off, size, d);
        #1 cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int off, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_off = 8'(off);
        #1 chk(req, 64'(cfg_rd_data), 64'(exp));
    endtask

    task automatic sample_txn(input string req);
        bit h; int s; logic [63:0] o;
        m_decode(txn_addr, int'(txn_len), txn_is_io, h, s, o);
        chk({req, " hit"}, 64'(hit_valid), 64'(h));
        if (h) begin
            chk({req, " slot"}, 64'(hit_slot), 64'(s));
            chk({req, " offset"}, hit_offset, o);
        end
    endtask

    task automatic txn_chk(input string req, input bit io, input logic [63:0] a, input int len);
        @(negedge clk);
        txn_valid = 1'b1; txn_is_io = io; txn_addr = a; txn_len = 4'(len);
        #1 sample_txn(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++; n_checks++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NS; i++) m_bar[i] = '0;
        m_io = 0; m_mem = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10 reset state, R3/R4/R5/R8 fixed low bits
        rd_chk("R10 cmd", 4, 32'h0);
        rd_chk("R3 io reset", 16, 32'h1);
        rd_chk("R4 mem32 reset", 20, 32'h0);
        rd_chk("R5 mem64 reset", 24, 32'hC);
        rd_chk("R8 unused reset", 32, 32'h0);
        rd_chk("R10 other offset", 8, 32'h0);
        txn_chk("R10 mem at zero", 1'b0, 64'h0, 4);
        chk("R10 no hit", 64'(hit_valid), 64'd0);

        // R1 sizing
        for (int s = 0; s < NS; s++) wr(16 + 4 * s, 4, 32'hFFFF_FFFF);
        rd_chk("R1 slot0", 16, 32'hFFFF_FFE1);
        rd_chk("R1 slot1", 20, 32'hFFFF_F000);
        rd_chk("R1 slot2", 24, 32'h0000_000C);
        rd_chk("R1 slot3", 28, 32'hFFFF_FFFE);
        rd_chk("R1 slot4", 32, 32'h0);
        rd_chk("R1 slot5", 36, 32'hFFFF_FF00);

        // program windows and enable both spaces
        wr(16, 4, 32'h0000_2000);
        wr(20, 4, 32'hE000_1000);
        wr(24, 4, 32'h0000_0000);
        wr(28, 4, 32'h0000_0003);
        wr(36, 4, 32'hE000_2000);
        wr(4, 2, 32'h3);
        rd_chk("R5 upper masked", 28, 32'h0000_0002);
        rd_chk("R6 cmd readback", 4, 32'h3);

        txn_chk("R7 io start", 1'b1, 64'h2000, 4);
        chk("R7 io start hit", 64'(hit_valid), 64'd1);
        txn_chk("R7 io top", 1'b1, 64'h201C, 4);
        chk("R7 io top offset", hit_offset, 64'h1C);
        txn_chk("R7 io straddle", 1'b1, 64'h201E, 4);
        chk("R7 io straddle miss", 64'(hit_valid), 64'd0);
        txn_chk("R7 io below", 1'b1, 64'h1FFF, 1);
        txn_chk("R7 mem32 end", 1'b0, 64'hE000_1FF8, 8);
        chk("R7 mem32 end offset", hit_offset, 64'hFF8);
        txn_chk("R7 mem32 cross", 1'b0, 64'hE000_1FFC, 8);
        chk("R7 mem32 cross miss", 64'(hit_valid), 64'd0);
        txn_chk("R5 mem64 window", 1'b0, 64'h2_1234_5678, 4);
        chk("R5 mem64 offset", hit_offset, 64'h1234_5678);
        txn_chk("R7 io at mem", 1'b1, 64'hE000_1000, 4);
        txn_chk("R7 zero length", 1'b0, 64'hE000_1000, 0);

        // R2 ignored writes, checked at the read port
        wr(20, 2, 32'h1234_5678);
        rd_chk("R2 halfword", 20, 32'hE000_1000);
        wr(22, 4, 32'h1234_5678);
        rd_chk("R2 unaligned", 20, 32'hE000_1000);
        wr(21, 1, 32'hFF);
        rd_chk("R2 byte", 20, 32'hE000_1000);

        // R8 unused slot
        wr(32, 4, 32'hFFFF_FFFF);
        rd_chk("R8 unused after write", 32, 32'h0);
        txn_chk("R8 no decode", 1'b0, 64'h0, 4);

        // R6 command gating
        wr(4, 1, 32'h1);
        txn_chk("R6 mem off", 1'b0, 64'hE000_1000, 4);
        chk("R6 mem off miss", 64'(hit_valid), 64'd0);
        txn_chk("R6 io still on", 1'b1, 64'h2004, 4);
        wr(4, 4, 32'h2);
        txn_chk("R6 io off", 1'b1, 64'h2004, 4);
        chk("R6 io off miss", 64'(hit_valid), 64'd0);
        wr(6, 2, 32'h0);
        rd_chk("R6 status write no effect", 4, 32'h2);
        wr(4, 4, 32'h3);

        // R9 write and decode in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_off = 8'd36; cfg_wr_size = 3'd4; cfg_wr_data = 32'hC000_0000;
        txn_valid = 1'b1; txn_is_io = 1'b0; txn_addr = 64'hC000_0010; txn_len = 4'd4;
        #1 sample_txn("R9 old base");
        chk("R9 old base miss", 64'(hit_valid), 64'd0);
        @(posedge clk);
        m_apply(36, 4, 32'hC000_0000);
        #1 cfg_wr_en = 1'b0;
        #1 sample_txn("R9 new base");
        chk("R9 new base offset", hit_offset, 64'h10);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                int s; int sz; int off;
                s = int'($urandom % NS);
                sz = ($urandom % 4 == 0) ? (($urandom % 2 == 0) ? 1 : 2) : 4;
                off = 16 + 4 * s + (($urandom % 5 == 0) ? 2 : 0);
                wr(off, sz, $urandom);
            end else if (op == 3) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom % 4 != 0) d[1:0] = 2'b11;
                wr(4, 4, d);
            end else if (op < 6) begin
                int off;
                off = int'($urandom % 48);
                rd_chk("R1 random read", off, m_read(off));
            end else begin
                int w; int r; int len; logic [63:0] span; logic [63:0] lim; logic [63:0] a;
                case ($urandom % 4)
                    0: w = 0;
                    1: w = 1;
                    2: w = 2;
                    default: w = 5;
                endcase
                span = 64'd1 << B_LG[w];
                lim = (span > 64'h10_0000) ? 64'h10_0000 : span;
                r = int'($urandom % 4);
                if (r == 0) a = m_base(w) - 64'($urandom % 8);
                else if (r == 1) a = m_base(w) + span - 64'($urandom % 12);
                else a = m_base(w) + (64'($urandom) & (lim - 64'd1));
                len = 1 << ($urandom % 4);
                txn_chk("R7 random", ($urandom % 6 == 0) ? (w != 0) : (w == 0), a, len);
            end
        end

        @(negedge clk) txn_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule